// File: doc/BRIEF.md
# Serial Interrupt Line Serializer

This block carries a peripheral's interrupt requests to a host over one shared, open-drain serial interrupt line that is timed by the bus clock. The host (or, in quiet mode, the peripheral itself) opens a frame with a long low pulse. A fixed train of three-clock slots follows, and the frame closes with a short stop pulse. During the first clock of each slot, the block pulls the line low if the request mapped to that slot is asserted. It then drives the line high for one clock and releases it for one clock.

Requests come from three register channels as level signals. The first channel owns interrupts 1 and 12. Each of the shared channels can raise a system-management request and interrupts 6, 9, 10 and 11. Requests that land on the same slot are merged. The width of the stop pulse chooses the mode for the frames that follow. In continuous mode only the host opens frames. In quiet mode the peripheral may open a frame when a new request appears.

The line is modelled as three signals: the sampled line level, a drive value and a drive enable. A board-level resolver combines them with the host's drive.

Top module: `serirq_serializer`

## Requirements
- R1: After reset the block is in continuous mode and keeps `line_oe` low until it sees a valid start frame: a run of at least START_MIN (default 4) consecutive low samples on `line_i` that ends in a high sample.
- R2: The clock after that ending high sample is the sample phase of slot 0, and slot n's sample phase begins 3n clocks later. There are NUM_SLOTS (default 16) slots per frame.
- R3: For an asserted slot, the block drives low (`line_oe`=1, `line_o`=0) in the sample clock, drives high (`line_oe`=1, `line_o`=1) in the next clock, and releases the line (`line_oe`=0) in the third clock.
- R4: `ch1_req[0]` maps to slot 1 and `ch1_req[1]` maps to slot 12.
- R5: In each shared channel c, `shared_req[c]` bit 0 (system-management request) maps to slot 2, bit 1 to slot 6, bit 2 to slot 9, bit 3 to slot 10 and bit 4 to slot 11. Equal slots from different channels are ORed, so they produce a single drive.
- R6: Slots with no mapped request, slots whose requests are deasserted, and the stop phase after the last slot are never driven.
- R7: After the last slot, the first low run on the line sets the mode when it ends. Exactly 2 low clocks select quiet mode, exactly 3 select continuous mode, and any other width leaves the mode unchanged.
- R8: In quiet mode, a rising request seen while the frame logic is idle makes the block drive the line low for exactly one clock, provided the line was high in the previous clock. It then releases the line. In continuous mode the block never starts a frame itself.
- R9: A request rise in quiet mode is remembered until the next start frame is detected. A rise that arrives after its slot has passed in a frame therefore causes a self-started frame once the block is idle again.
- R10: While slots are running, the line level is ignored: low pulses from the host neither restart nor shorten the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Resolved level of the serial interrupt line |
| line_o | output | 1 | Value driven onto the line when enabled |
| line_oe | output | 1 | Drive enable for the line |
| ch1_req | input | 2 | Channel 1 request levels (interrupt 1, interrupt 12) |
| shared_req | input | N_SHARED x 5 | Request levels of the shared channels, per channel: SMI, 6, 9, 10, 11 |

## Verification
Several properties are checked on every cycle:
- a driven sample clock is followed by a driven-high recovery clock;
- the turnaround clock and the stop phase stay released;
- slots advance one step per three clocks;
- a frame cannot be cut short;
- stop widths of 2 and 3 select the mode;
- a self-start pulse lasts one clock;
- nothing is driven outside slots unless the block is in quiet mode.

Other behaviours can only be shown by the bench's scenarios. These are the exact slot each request reaches, the merging of channels onto one slot, and mid-frame host glitches being ignored. They also include a late request producing a self-started frame, and a stop width of 5 leaving the mode untouched. A behavioural model compares the line outputs on every clock.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

   localparam int CH1_W    = 2;
   localparam int SHARED_W = 5;

   // slots used by the first channel
   localparam int SLOT_IRQ1  = 1;
   localparam int SLOT_IRQ12 = 12;
   localparam int MIN_SLOTS  = 13;

   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_SLOTS = 2'd1,
      FR_STOP  = 2'd2
   } fr_state_e;

   typedef enum logic [1:0] {
      PH_SAMPLE  = 2'd0,
      PH_RECOVER = 2'd1,
      PH_TURN    = 2'd2
   } slot_phase_e;

   // slot carried by bit b of a shared channel
   function automatic int shared_slot(input int b);
      case (b)
         0:       return 2;
         1:       return 6;
         2:       return 9;
         3:       return 10;
         default: return 11;
      endcase
   endfunction

endpackage

// File: rtl/serirq_slot_map.sv
module serirq_slot_map
   import serirq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int N_SHARED  = 2
) (
   input  logic [CH1_W-1:0]                   ch1_req,
   input  logic [N_SHARED-1:0][SHARED_W-1:0]  shared_req,
   output logic [NUM_SLOTS-1:0]               slot_req
);

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_comb begin
         logic v;
         v = 1'b0;
         if (s == SLOT_IRQ1)  v = v | ch1_req[0];
         if (s == SLOT_IRQ12) v = v | ch1_req[1];
         for (int c = 0; c < N_SHARED; c++) begin
            for (int b = 0; b < SHARED_W; b++) begin
               if (shared_slot(b) == s) v = v | shared_req[c][b];
            end
         end
         slot_req[s] = v;
      end
   end

endmodule

// File: rtl/serirq_frame_fsm.sv
module serirq_frame_fsm
   import serirq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int START_MIN = 4,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int CNT_W    = $clog2(START_MIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output fr_state_e         st,
   output slot_phase_e       ph,
   output logic [SLOT_W-1:0] slot,
   output logic              quiet,
   output logic              start_seen
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
   localparam logic [CNT_W-1:0]  LOW_SAT   = CNT_W'(START_MIN);
   localparam logic [CNT_W-1:0]  W_QUIET   = CNT_W'(2);
   localparam logic [CNT_W-1:0]  W_CONT    = CNT_W'(3);

   logic [CNT_W-1:0] lowcnt;
   logic             stop_end;

   assign start_seen = (st == FR_IDLE) && line_i && (lowcnt >= LOW_SAT);
   assign stop_end   = (st == FR_STOP) && line_i && (lowcnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= FR_IDLE;
         ph     <= PH_SAMPLE;
         slot   <= '0;
         lowcnt <= '0;
         quiet  <= 1'b0;
      end else begin
         if (line_i)                lowcnt <= '0;
         else if (lowcnt != LOW_SAT) lowcnt <= lowcnt + CNT_W'(1);

         case (st)
            FR_IDLE: begin
               if (start_seen) begin
                  st   <= FR_SLOTS;
                  ph   <= PH_SAMPLE;
                  slot <= '0;
               end
            end
            FR_SLOTS: begin
               case (ph)
                  PH_SAMPLE:  ph <= PH_RECOVER;
                  PH_RECOVER: ph <= PH_TURN;
                  default: begin
                     ph <= PH_SAMPLE;
                     if (slot == LAST_SLOT) begin
                        st   <= FR_STOP;
                        slot <= '0;
                     end else begin
                        slot <= slot + SLOT_W'(1);
                     end
                  end
               endcase
            end
            FR_STOP: begin
               if (stop_end) begin
                  st <= FR_IDLE;
                  if (lowcnt == W_QUIET)     quiet <= 1'b1;
                  else if (lowcnt == W_CONT) quiet <= 1'b0;
               end
            end
            default: st <= FR_IDLE;
         endcase
      end
   end

   // R2
   slot_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_SLOTS && ph == PH_TURN && slot != LAST_SLOT)
      |=> (st == FR_SLOTS && ph == PH_SAMPLE && slot == $past(slot) + SLOT_W'(1)));

   // R10
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_SLOTS && !(ph == PH_TURN && slot == LAST_SLOT)) |=> (st == FR_SLOTS));

   // R7
   quiet_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_end && lowcnt == W_QUIET) |=> quiet);

   // R7
   cont_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_end && lowcnt == W_CONT) |=> !quiet);

endmodule

// File: rtl/serirq_quiet_starter.sv
module serirq_quiet_starter #(
   parameter int NUM_SLOTS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 line_i,
   input  logic                 idle,
   input  logic                 quiet,
   input  logic                 start_seen,
   input  logic [NUM_SLOTS-1:0] slot_req,
   output logic                 drive_start
);

   logic [NUM_SLOTS-1:0] prev_req;
   logic                 pend;
   logic                 hi_q;
   logic                 rise;

   assign rise        = |(slot_req & ~prev_req);
   assign drive_start = idle && quiet && pend && hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_req <= '0;
         pend     <= 1'b0;
         hi_q     <= 1'b1;
      end else begin
         prev_req <= slot_req;
         hi_q     <= line_i;
         if (drive_start || start_seen) pend <= 1'b0;
         else if (rise && quiet)        pend <= 1'b1;
      end
   end

   // R8
   one_clk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drive_start |=> !drive_start);

   // R9
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_seen |=> !pend);

endmodule

// File: rtl/serirq_serializer.sv
module serirq_serializer
   import serirq_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int START_MIN = 4,
   parameter int N_SHARED  = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               line_i,
   output logic                               line_o,
   output logic                               line_oe,
   input  logic [CH1_W-1:0]                   ch1_req,
   input  logic [N_SHARED-1:0][SHARED_W-1:0]  shared_req
);

   localparam int SLOT_W = $clog2(NUM_SLOTS);

   if (NUM_SLOTS < MIN_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS must cover slot 12");
   end
   if (START_MIN < 4) begin : g_bad_start
      $error("START_MIN must exceed the stop widths");
   end
   if (N_SHARED < 1) begin : g_bad_shared
      $error("N_SHARED must be at least 1");
   end

   logic [NUM_SLOTS-1:0] slot_req;
   fr_state_e            st;
   slot_phase_e          ph;
   logic [SLOT_W-1:0]    slot;
   logic                 quiet;
   logic                 start_seen;
   logic                 drive_start;
   logic                 drove_q;
   logic                 drive_low;

   serirq_slot_map #(.NUM_SLOTS(NUM_SLOTS), .N_SHARED(N_SHARED)) u_map (
      .ch1_req    (ch1_req),
      .shared_req (shared_req),
      .slot_req   (slot_req)
   );

   serirq_frame_fsm #(.NUM_SLOTS(NUM_SLOTS), .START_MIN(START_MIN)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_i     (line_i),
      .st         (st),
      .ph         (ph),
      .slot       (slot),
      .quiet      (quiet),
      .start_seen (start_seen)
   );

   serirq_quiet_starter #(.NUM_SLOTS(NUM_SLOTS)) u_qs (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line_i),
      .idle        (st == FR_IDLE),
      .quiet       (quiet),
      .start_seen  (start_seen),
      .slot_req    (slot_req),
      .drive_start (drive_start)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                                drove_q <= 1'b0;
      else if (st == FR_SLOTS && ph == PH_SAMPLE) drove_q <= slot_req[slot];
   end

   assign drive_low = drive_start || (st == FR_SLOTS && ph == PH_SAMPLE && slot_req[slot]);
   assign line_oe   = drive_low || (st == FR_SLOTS && ph == PH_RECOVER && drove_q);
   assign line_o    = !drive_low;

   // R3
   recover_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_SLOTS && ph == PH_SAMPLE && line_oe) |=> (line_oe && line_o));

   // R3
   turn_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_SLOTS && ph == PH_TURN) |-> !line_oe);

   // R6
   stop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_STOP) |-> !line_oe);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_IDLE && line_oe) |-> (quiet && !line_o));

endmodule

// File: tb/tb_serirq_serializer.sv
module tb_serirq_serializer;

   localparam int NS = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            host_low = 1'b0;
   logic [1:0]      ch1 = '0;
   logic [1:0][4:0] sh = '0;
   logic            line_o, line_oe, line_i;

   always #2 clk = ~clk;

   assign line_i = (host_low || (line_oe && !line_o)) ? 1'b0 : 1'b1;

   serirq_serializer dut (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_o(line_o),
      .line_oe(line_oe), .ch1_req(ch1), .shared_req(sh)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, act, expv, $time);
      end
   endtask

   // ---------------- behavioural model ----------------
   int m_st, m_cnt, m_low, m_quiet, m_pend, m_hi, m_drove;
   bit [NS-1:0] m_prev;

   function automatic bit [NS-1:0] req_map();
      bit [NS-1:0] v = '0;
      v[1]  = ch1[0];
      v[12] = ch1[1];
      for (int c = 0; c < 2; c++) begin
         v[2]  |= sh[c][0];
         v[6]  |= sh[c][1];
         v[9]  |= sh[c][2];
         v[10] |= sh[c][3];
         v[11] |= sh[c][4];
      end
      return v;
   endfunction

   function automatic bit m_drive_low();
      bit [NS-1:0] r = req_map();
      if (m_st == 0) return (m_quiet != 0) && (m_pend != 0) && (m_hi != 0);
      if (m_st == 1) return (m_cnt % 3 == 0) && r[m_cnt / 3];
      return 1'b0;
   endfunction

   function automatic bit m_oe();
      return m_drive_low() || (m_st == 1 && m_cnt % 3 == 1 && m_drove != 0);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_low = 0; m_quiet = 0;
         m_pend = 0; m_hi = 1; m_drove = 0; m_prev = '0;
      end else begin
         bit [NS-1:0] r;
         bit L, ds, st_ok, rise;
         r     = req_map();
         L     = !(host_low || m_drive_low());
         ds    = (m_st == 0) && m_quiet != 0 && m_pend != 0 && m_hi != 0;
         st_ok = (m_st == 0) && L && m_low >= 4;
         rise  = |(r & ~m_prev);
         if (ds || st_ok)            m_pend = 0;
         else if (rise && m_quiet != 0) m_pend = 1;
         if (m_st == 0) begin
            if (st_ok) begin m_st = 1; m_cnt = 0; end
         end else if (m_st == 1) begin
            if (m_cnt % 3 == 0) m_drove = r[m_cnt / 3];
            m_cnt++;
            if (m_cnt == 3 * NS) m_st = 2;
         end else begin
            if (L && m_low > 0) begin
               m_st = 0;
               if (m_low == 2) m_quiet = 1;
               else if (m_low == 3) m_quiet = 0;
            end
         end
         m_low  = L ? 0 : m_low + 1;
         m_hi   = L;
         m_prev = r;
      end
   end

   // per-clock comparison against the model
   always begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
         string tag;
         bit eo;
         tag = (m_st == 1) ? "R2/R3" : (m_st == 2) ? "R6" : (m_quiet != 0) ? "R8" : "R1";
         eo = m_oe();
         chk(line_oe == eo, {tag, " line_oe"}, int'(line_oe), int'(eo));
         if (eo) chk(line_o == !m_drive_low(), {tag, " line_o"}, int'(line_o), int'(!m_drive_low()));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic host_start(input int w);
      @(negedge clk); host_low = 1'b1;
      repeat (w - 1) @(negedge clk);
      @(negedge clk); host_low = 1'b0;
   endtask

   task automatic wait_self_start(input string tag);
      bit seen = 1'b0;
      for (int k = 0; k < 6 && !seen; k++) begin
         @(negedge clk); #1;
         if (line_oe && !line_o) seen = 1'b1;
      end
      chk(seen, {tag, " self-start drive"}, int'(seen), 1);
      host_low = 1'b1;
      @(negedge clk); #1;
      chk(!line_oe, "R8 self-start one clock", int'(line_oe), 0);
      repeat (3) @(negedge clk);
      host_low = 1'b0;
   endtask

   task automatic capture(input bit [NS-1:0] expv, input string tag,
                          input int late_j, input int glitch_j);
      bit [NS-1:0] got = '0;
      for (int j = 0; j < 3 * NS; j++) begin
         @(negedge clk);
         if (j == late_j) ch1[0] = 1'b1;
         if (j == glitch_j) host_low = 1'b1;
         if (j == glitch_j + 2) host_low = 1'b0;
         #1;
         if (line_oe && !line_o) begin
            if (j % 3 != 0) chk(1'b0, "R3 low outside sample clock", j, (j / 3) * 3);
            else got[j / 3] = 1'b1;
         end
      end
      chk(got == expv, {tag, " driven slots"}, int'(got), int'(expv));
   endtask

   task automatic host_stop(input int w);
      @(negedge clk); host_low = 1'b1;
      repeat (w - 1) @(negedge clk);
      @(negedge clk); host_low = 1'b0;
   endtask

   task automatic expect_silent(input int n, input string tag);
      int drv = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk); #1;
         if (line_oe) drv++;
      end
      chk(drv == 0, tag, drv, 0);
   endtask

   // ---------------- scenarios ----------------
   initial begin
      bit [NS-1:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      ch1 = 2'b11;
      // R1: no drive before any start frame, even with requests up
      expect_silent(6, "R1 silent after reset");

      // B: continuous frame, R4 and R5 mapping
      sh[0] = 5'b00001;
      sh[1] = 5'b10100;
      host_start(6);
      e = '0; e[1] = 1; e[12] = 1; e[2] = 1; e[9] = 1; e[11] = 1;
      capture(e, "R4/R5/R6", -1, -1);
      host_stop(2);
      expect_silent(2, "R6 no self-start without rise");

      // C: quiet self-start, late request rise inside the frame
      @(negedge clk); ch1 = '0; sh = '0;
      repeat (2) @(negedge clk);
      sh[0][1] = 1'b1;
      wait_self_start("R8");
      e = '0; e[6] = 1;
      capture(e, "R5 slot6", 20, -1);
      host_stop(2);

      // D: remembered rise opens the next frame
      wait_self_start("R9");
      e = '0; e[1] = 1; e[6] = 1;
      capture(e, "R9 late request", -1, -1);
      host_stop(3);

      // E: continuous, merged slot, host glitch during slots, stop width 5
      @(negedge clk); ch1 = '0; sh = '0;
      repeat (2) @(negedge clk);
      sh[1][3] = 1'b1; sh[0][3] = 1'b1;
      expect_silent(6, "R8 continuous has no self-start");
      host_start(5);
      e = '0; e[10] = 1;
      capture(e, "R10/R5 merge", -1, 30);
      host_stop(5);
      @(negedge clk); sh = '0;
      repeat (2) @(negedge clk);
      sh[1][4] = 1'b1;
      expect_silent(6, "R7 width 5 keeps continuous");

      // F: stop width 2 switches to quiet
      host_start(4);
      e = '0; e[11] = 1;
      capture(e, "R5 slot11", -1, -1);
      host_stop(2);
      @(negedge clk); sh = '0;
      repeat (2) @(negedge clk);
      ch1[1] = 1'b1;
      wait_self_start("R7 quiet after width 2");
      e = '0; e[12] = 1;
      capture(e, "R4 slot12", -1, -1);
      host_stop(3);
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule